// File: doc/BRIEF.md
# Local-History Two-Level Branch Predictor

This block predicts conditional branch direction using two levels of state. The first level is a small file of per-branch shift registers. Each one records the last three resolved outcomes of the branches that map to it. The second level is a single table of 2-bit saturating counters, shared by every branch and indexed only by a history value. A lookup selects a history register from the branch address, reads the counter that history points to, and returns that counter's upper bit as the predicted direction one cycle later.

Resolved branches come back through a separate update port. The update trains the counter addressed by the branch's history as it stood before the outcome arrived. In the same cycle, the outcome is shifted into that branch's history register. Branches that share the same recent history train the same counter, so they can help or disturb each other.

Every history register and every counter is also driven out on flat debug buses. A testbench can use them to compare the whole predictor state against a reference model after any sequence of updates.

Top module: `lhist_predictor`

## Requirements
- R1: After a synchronous reset, every history register holds 000, every pattern counter holds 2'b10 (weakly taken), and pred_valid is 0.
- R2: A lookup presented with lk_valid=1 at a rising edge produces pred_valid=1 after that edge. pred_taken equals bit 1 of the counter indexed by the selected branch's history (1 = taken). A cycle without lk_valid produces pred_valid=0.
- R3: The history register is chosen by address bits [4:2] only. Two addresses that agree in bits [4:2] use the same history register, whatever their other bits are.
- R4: An update trains the counter indexed by the selected branch's history before the shift. A taken outcome (up_taken=1) increments the counter, stopping at 2'b11. A not-taken outcome decrements it, stopping at 2'b00.
- R5: An update replaces the selected history h with {h[1:0], up_taken}, so the newest outcome enters bit 0. The other history registers keep their values.
- R6: The pattern table is shared. When two different branches hold the same history value, an update to one of them changes the counter that the other reads.
- R7: When a lookup and an update hit the same branch in the same cycle, the prediction uses the history and counter values from before that update.
- R8: While up_valid is 0, no history register and no counter changes, whatever up_pc and up_taken carry.
- R9: The debug buses place history register i at dbg_hist[3*i+2:3*i] and counter j at dbg_ctr[2*j+1:2*j].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 32 | Address of the branch being predicted |
| pred_valid | output | 1 | Registered: a prediction is present |
| pred_taken | output | 1 | Registered predicted direction, 1 = taken |
| up_valid | input | 1 | Update request |
| up_pc | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Resolved direction, 1 = taken |
| dbg_hist | output | 24 | All eight history registers, flattened |
| dbg_ctr | output | 16 | All eight pattern counters, flattened |

## Verification
A prediction is due one clock after the edge that samples lk_valid, because there is a single output register on that path. An update is visible on the debug buses right after the edge that samples up_valid. The bench drives every input on a falling edge, lets exactly one rising edge pass, and samples on the next falling edge. It computes the expected prediction from its own model before applying any same-cycle update, so the old-history rule of R7 is checked at the point where it matters.

// File: rtl/lhp_pkg.sv
`timescale 1ns/1ps
package lhp_pkg;
  localparam int CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_INIT = 2'b10;

  function automatic ctr_t ctr_train(input ctr_t cur, input logic taken);
    ctr_t nxt;
    nxt = cur;
    if (taken) begin
      if (cur != {CTR_W{1'b1}}) nxt = cur + 1'b1;
    end else begin
      if (cur != '0) nxt = cur - 1'b1;
    end
    return nxt;
  endfunction
endpackage

// File: rtl/lhp_hist_file.sv
`timescale 1ns/1ps
module lhp_hist_file #(
  parameter int SEL_W  = 3,
  parameter int HIST_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [SEL_W-1:0]            wr_sel,
  input  logic                        wr_bit,
  input  logic [SEL_W-1:0]            rd_sel_a,
  output logic [HIST_W-1:0]           rd_hist_a,
  input  logic [SEL_W-1:0]            rd_sel_b,
  output logic [HIST_W-1:0]           rd_hist_b,
  output logic [(1<<SEL_W)*HIST_W-1:0] all_hist
);
  localparam int NREG = 1 << SEL_W;

  logic [HIST_W-1:0] hist_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        hist_q[i] <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(i))) begin
        hist_q[i] <= {hist_q[i][HIST_W-2:0], wr_bit};
      end
    end
    assign all_hist[i*HIST_W +: HIST_W] = hist_q[i];
  end

  assign rd_hist_a = hist_q[rd_sel_a];
  assign rd_hist_b = hist_q[rd_sel_b];
endmodule

// File: rtl/lhp_pattern_table.sv
`timescale 1ns/1ps
module lhp_pattern_table
  import lhp_pkg::*;
#(
  parameter int HIST_W = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [HIST_W-1:0]                rd_idx,
  output ctr_t                             rd_ctr,
  input  logic                             wr_en,
  input  logic [HIST_W-1:0]                wr_idx,
  input  logic                             wr_taken,
  output logic [(1<<HIST_W)*CTR_W-1:0]     all_ctr
);
  localparam int DEPTH = 1 << HIST_W;

  ctr_t ctr_q [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ctr_q[j] <= CTR_INIT;
      end else if (wr_en && (wr_idx == HIST_W'(j))) begin
        ctr_q[j] <= ctr_train(ctr_q[j], wr_taken);
      end
    end
    assign all_ctr[j*CTR_W +: CTR_W] = ctr_q[j];
  end

  assign rd_ctr = ctr_q[rd_idx];
endmodule

// File: rtl/lhp_pred_reg.sv
`timescale 1ns/1ps
module lhp_pred_reg (
  input  logic clk,
  input  logic rst,
  input  logic vld_d,
  input  logic dir_d,
  output logic vld_q,
  output logic dir_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      dir_q <= vld_d ? dir_d : 1'b0;
    end
  end
endmodule

// File: rtl/lhist_predictor.sv
`timescale 1ns/1ps
module lhist_predictor
  import lhp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int SEL_LO = 2,
  parameter int SEL_W  = 3,
  parameter int HIST_W = 3
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              lk_valid,
  input  logic [PC_W-1:0]                   lk_pc,
  output logic                              pred_valid,
  output logic                              pred_taken,
  input  logic                              up_valid,
  input  logic [PC_W-1:0]                   up_pc,
  input  logic                              up_taken,
  output logic [(1<<SEL_W)*HIST_W-1:0]      dbg_hist,
  output logic [(1<<HIST_W)*CTR_W-1:0]      dbg_ctr
);
  logic [SEL_W-1:0]  lk_sel, up_sel;
  logic [HIST_W-1:0] lk_hist, up_hist;
  ctr_t              lk_ctr;

  assign lk_sel = lk_pc[SEL_LO +: SEL_W];
  assign up_sel = up_pc[SEL_LO +: SEL_W];

  lhp_hist_file #(.SEL_W(SEL_W), .HIST_W(HIST_W)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (up_valid),
    .wr_sel    (up_sel),
    .wr_bit    (up_taken),
    .rd_sel_a  (lk_sel),
    .rd_hist_a (lk_hist),
    .rd_sel_b  (up_sel),
    .rd_hist_b (up_hist),
    .all_hist  (dbg_hist)
  );

  lhp_pattern_table #(.HIST_W(HIST_W)) u_pht (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (lk_hist),
    .rd_ctr   (lk_ctr),
    .wr_en    (up_valid),
    .wr_idx   (up_hist),
    .wr_taken (up_taken),
    .all_ctr  (dbg_ctr)
  );

  lhp_pred_reg u_out (
    .clk   (clk),
    .rst   (rst),
    .vld_d (lk_valid),
    .dir_d (lk_ctr[CTR_W-1]),
    .vld_q (pred_valid),
    .dir_q (pred_taken)
  );
endmodule

// File: rtl/lhp_checker.sv
`timescale 1ns/1ps
module lhp_checker
  import lhp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int SEL_LO = 2,
  parameter int SEL_W  = 3,
  parameter int HIST_W = 3
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         lk_valid,
  input logic                         pred_valid,
  input logic                         up_valid,
  input logic [PC_W-1:0]              up_pc,
  input logic                         up_taken,
  input logic [(1<<SEL_W)*HIST_W-1:0] dbg_hist,
  input logic [(1<<HIST_W)*CTR_W-1:0] dbg_ctr
);
  logic [SEL_W-1:0]  cur_sel, prev_sel;
  logic [HIST_W-1:0] cur_hist, prev_hist;
  ctr_t              cur_ctr, prev_ctr;
  logic              prev_taken;

  assign cur_sel  = up_pc[SEL_LO +: SEL_W];
  assign cur_hist = dbg_hist[int'(cur_sel)*HIST_W +: HIST_W];
  assign cur_ctr  = dbg_ctr[int'(cur_hist)*CTR_W +: CTR_W];

  always_ff @(posedge clk) begin
    prev_sel   <= cur_sel;
    prev_hist  <= cur_hist;
    prev_ctr   <= cur_ctr;
    prev_taken <= up_taken;
  end

  AST_PRED_FOLLOWS_LOOKUP: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_valid); // R2
  AST_NO_SPURIOUS_PRED: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !pred_valid); // R2
  AST_HIST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> dbg_hist[int'(prev_sel)*HIST_W +: HIST_W] == {prev_hist[HIST_W-2:0], prev_taken}); // R5
  AST_CTR_TRAINED: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> dbg_ctr[int'(prev_hist)*CTR_W +: CTR_W] == ctr_train(prev_ctr, prev_taken)); // R4
  AST_HIST_IDLE: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> $stable(dbg_hist)); // R8
  AST_CTR_IDLE: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> $stable(dbg_ctr)); // R8
endmodule

bind lhist_predictor lhp_checker #(
  .PC_W(PC_W), .SEL_LO(SEL_LO), .SEL_W(SEL_W), .HIST_W(HIST_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lk_valid   (lk_valid),
  .pred_valid (pred_valid),
  .up_valid   (up_valid),
  .up_pc      (up_pc),
  .up_taken   (up_taken),
  .dbg_hist   (dbg_hist),
  .dbg_ctr    (dbg_ctr)
);

// File: tb/sim_lhist_predictor.sv
`timescale 1ns/1ps
module sim_lhist_predictor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        pred_valid, pred_taken;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 1'b0;
  logic [23:0] dbg_hist;
  logic [15:0] dbg_ctr;

  int n_chk = 0;
  int n_bad = 0;

  logic [2:0] m_hist [8];
  logic [1:0] m_ctr  [8];

  always #2 clk = ~clk;

  lhist_predictor u0 (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .dbg_hist(dbg_hist), .dbg_ctr(dbg_ctr)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin
      m_hist[i] = 3'b000;
      m_ctr[i]  = 2'b10;
    end
  endtask

  task automatic model_update(input logic [31:0] pc, input logic t);
    logic [2:0] s, h;
    s = pc[4:2];
    h = m_hist[s];
    if (t && m_ctr[h] != 2'b11) m_ctr[h] = m_ctr[h] + 2'd1;
    if (!t && m_ctr[h] != 2'b00) m_ctr[h] = m_ctr[h] - 2'd1;
    m_hist[s] = {h[1:0], t};
  endtask

  // R9 layout: register i at [3i+2:3i], counter j at [2j+1:2j]
  task automatic check_state(input string req);
    for (int i = 0; i < 8; i++)
      chk(dbg_hist[3*i +: 3] == m_hist[i], {req, " R9 hist"}, int'(dbg_hist[3*i +: 3]), int'(m_hist[i]));
    for (int j = 0; j < 8; j++)
      chk(dbg_ctr[2*j +: 2] == m_ctr[j], {req, " R9 ctr"}, int'(dbg_ctr[2*j +: 2]), int'(m_ctr[j]));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    lk_valid = 1'b0;
    up_valid = 1'b0;
    step();
    step();
    rst = 1'b0;
    model_reset();
  endtask

  task automatic lookup_check(input logic [31:0] pc, input string req);
    logic e;
    e = m_ctr[m_hist[pc[4:2]]][1];
    lk_valid = 1'b1;
    lk_pc = pc;
    step();
    lk_valid = 1'b0;
    chk(pred_valid == 1'b1, {req, " R2 valid"}, int'(pred_valid), 1);
    chk(pred_taken == e, req, int'(pred_taken), int'(e));
  endtask

  task automatic update(input logic [31:0] pc, input logic t, input string req);
    up_valid = 1'b1;
    up_pc = pc;
    up_taken = t;
    step();
    up_valid = 1'b0;
    model_update(pc, t);
    check_state(req);
  endtask

  // R1: reset values
  task automatic t_reset();
    do_reset();
    chk(pred_valid == 1'b0, "R1 pred_valid", int'(pred_valid), 0);
    check_state("R1");
  endtask

  // R2 R4 R5 R6: three branches of a loop, shared table
  task automatic t_loop();
    int r;
    logic t2;
    do_reset();
    r = 999999;
    for (int pass = 0; pass < 8; pass++) begin
      t2 = ((r % 4) == 3);
      lookup_check(32'h0000_0008, "R2 loop L2");
      update(32'h0000_0008, t2, "R4 R5 loop L2");
      if (!t2) begin
        lookup_check(32'h0000_0014, "R6 loop L5");
        update(32'h0000_0014, 1'b1, "R6 loop L5");
      end
      lookup_check(32'h0000_0024, "R2 loop L10");
      update(32'h0000_0024, 1'b1, "R5 loop L10");
      r = r - 2;
    end
  endtask

  // R3: upper address bits do not pick a different register
  task automatic t_alias();
    do_reset();
    update(32'h1000_0008, 1'b0, "R3 alias a");
    update(32'hABC0_0008, 1'b0, "R3 alias b");
    chk(dbg_hist[6 +: 3] == 3'b000 && dbg_ctr[1:0] == 2'b00, "R3 alias hist/ctr",
        int'(dbg_ctr[1:0]), 0);
    lookup_check(32'hFFFF_FFE8, "R3 alias lookup");
    chk(pred_taken == 1'b0, "R3 alias pred", int'(pred_taken), 0);
  endtask

  // R4: saturation at both ends
  task automatic t_saturate();
    do_reset();
    for (int k = 0; k < 4; k++) update(32'h0000_0000, 1'b0, "R4 sat low");
    chk(dbg_ctr[1:0] == 2'b00, "R4 floor", int'(dbg_ctr[1:0]), 0);
    for (int k = 0; k < 6; k++) update(32'h0000_001C, 1'b1, "R4 sat high");
    chk(dbg_ctr[15:14] == 2'b11, "R4 ceiling", int'(dbg_ctr[15:14]), 3);
    chk(dbg_hist[21 +: 3] == 3'b111, "R5 all ones", int'(dbg_hist[21 +: 3]), 7);
  endtask

  // R7: lookup and update to the same branch in one cycle
  task automatic t_same_cycle();
    logic e;
    do_reset();
    update(32'h0000_0010, 1'b0, "R7 prep");
    update(32'h0000_0000, 1'b0, "R7 prep2");
    e = m_ctr[m_hist[3'd4]][1];
    lk_valid = 1'b1; lk_pc = 32'h0000_0010;
    up_valid = 1'b1; up_pc = 32'h0000_0010; up_taken = 1'b1;
    step();
    lk_valid = 1'b0; up_valid = 1'b0;
    model_update(32'h0000_0010, 1'b1);
    chk(pred_taken == e, "R7 old-history prediction", int'(pred_taken), int'(e));
    check_state("R7");
    lookup_check(32'h0000_0010, "R7 after");
  endtask

  // R8: update inputs ignored while up_valid is low
  task automatic t_idle();
    do_reset();
    update(32'h0000_000C, 1'b1, "R8 prep");
    for (int k = 0; k < 5; k++) begin
      up_pc = 32'h0000_0004 * k;
      up_taken = k[0];
      step();
    end
    check_state("R8 idle");
    chk(pred_valid == 1'b0, "R8 R2 no lookup", int'(pred_valid), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_loop();
    t_alias();
    t_saturate();
    t_same_cycle();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule